// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns the system clock into CAN time quanta and walks every nominal bit through three consecutive segments. The first is a one-quantum synchronisation segment, then time segment one (propagation delay plus the first phase segment), then time segment two. It raises a one-clock transmit-point strobe in the first clock of every bit. It raises a one-clock sample strobe in the first clock of time segment two, together with the bus value taken at the boundary between the two time segments. That value is either a single sample or a majority vote over three samples.

Software programs the timing through two byte-wide registers: the quantum prescaler, the two segment lengths and a sampling-mode bit. These registers are shadow copies. Writes are taken only while the initialisation bit is set and the controller is not bus-off. The shadow values become the active timing only when software clears the initialisation bit. If both segment fields are zero at that moment, the transfer is refused and the active timing stays as it was. While initialisation is set the sequencer idles. While it runs, a recessive-to-dominant edge on the receive line restarts the bit (hard synchronisation), provided the last sampled bus value was recessive.

Top module: `can_bit_timer`

## Requirements
- R1: After reset, init_o is 1, tx_pt and smp_stb are 0, smp_bit is 1 (recessive), and all timing fields are zero.
- R2: One time quantum lasts prescaler+1 clocks. A bit lasts 1+T1+T2 quanta. tx_pt is a one-clock pulse in the first clock of every bit.
- R3: Register select 0 holds the prescaler in bits [5:0]. Register select 1 holds the time segment one field in [3:0], the time segment two field in [6:4] and the sampling mode in [7] (1 = three samples). T1 = max(field,1)+1 quanta (2..16) and T2 = max(field,1)+1 quanta (2..8).
- R4: smp_stb is a one-clock pulse exactly (1+T1)·(prescaler+1) clocks after the bit's tx_pt, that is, in the first clock of time segment two. smp_bit changes only together with smp_stb.
- R5: In single-sample mode, smp_bit is rx as seen in the last clock of time segment one.
- R6: In three-sample mode, smp_bit is the majority of rx in the last clock of each of the last three quanta of time segment one.
- R7: Timing register writes take effect only while init_o is 1 and bus_off is 0. All other writes are ignored.
- R8: The active timing is loaded from the shadow registers only when init_o goes from 1 to 0. The first bit begins in the clock after that transition.
- R9: If both segment fields are zero when init_o clears, no field is loaded and the active timing is unchanged. With no timing ever loaded, no bit activity occurs.
- R10: While init_o is 1, the sequencer is idle and tx_pt stays 0.
- R11: While running with smp_bit recessive, a clock in which rx is 0 after being 1 in the previous clock makes the next clock the first clock of a new bit, and no sample is taken in the edge clock.
- R12: While smp_bit is dominant (0), falling edges on rx do not restart the bit.
- R13: An init_wr strobe loads init_val into the initialisation bit, which is visible on init_o in the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_sel | input | 1 | Register select: 0 prescaler, 1 segments and mode |
| cfg_wdata | input | 8 | Timing register write data |
| init_wr | input | 1 | Strobe to write the initialisation bit |
| init_val | input | 1 | Value written to the initialisation bit |
| bus_off | input | 1 | Controller is bus-off; blocks timing writes |
| rx | input | 1 | Receive bus level, 1 = recessive |
| init_o | output | 1 | Current initialisation bit |
| tx_pt | output | 1 | Transmit-point strobe, first clock of each bit |
| smp_stb | output | 1 | Sample strobe, first clock of time segment two |
| smp_bit | output | 1 | Last sampled bus value |

## Verification
The bench builds the block with its default field widths: a 6-bit prescaler, a 4-bit time segment one field and a 3-bit time segment two field. With these it can reach the longest bit, a 64-clock quantum times 25 quanta, in a few thousand clocks. It can also reach the shortest one-clock quantum and both clamp floors of two quanta. A short bit of 2-clock quanta is used to place rx levels quantum by quantum, so that the three-sample vote and single-point sampling give different answers. The same bit is used for hard synchronisation with the last sample recessive and with it dominant.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

    localparam int PRESC_W  = 6;
    localparam int TSEG1_W  = 4;
    localparam int TSEG2_W  = 3;
    localparam int REG_W    = 8;

    localparam int MAX_T1   = 1 << TSEG1_W;
    localparam int MAX_T2   = 1 << TSEG2_W;
    localparam int MAX_BIT  = 1 + MAX_T1 + MAX_T2;
    localparam int POS_W    = $clog2(MAX_BIT);

    localparam int T1_LSB   = 0;
    localparam int T2_LSB   = TSEG1_W;
    localparam int MODE_BIT = TSEG1_W + TSEG2_W;

    typedef struct packed {
        logic [PRESC_W-1:0] presc;
        logic [TSEG1_W-1:0] tseg1;
        logic [TSEG2_W-1:0] tseg2;
        logic               triple;
    } bt_cfg_t;

    // segment length in quanta: field plus one, with the field floored at one
    function automatic logic [POS_W-1:0] seg_len(input logic [POS_W-1:0] f);
        return (f == '0) ? POS_W'(2) : f + POS_W'(1);
    endfunction

endpackage

// File: rtl/bt_cfg_regs.sv
module bt_cfg_regs
    import can_bt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             init_wr,
    input  logic             init_val,
    input  logic             bus_off,
    output logic             init_o,
    output bt_cfg_t          act_o,
    output logic             run_o
);

    typedef struct packed {
        logic    init;
        logic    valid;
        bt_cfg_t shadow;
        bt_cfg_t active;
    } cfg_state_t;

    localparam cfg_state_t CFG_RST = '{init: 1'b1, valid: 1'b0, shadow: '0, active: '0};

    cfg_state_t s_d, s_q;
    logic       wr_ok;
    logic       zero_seg;
    logic       init_fall;

    always_comb begin
        s_d       = s_q;
        wr_ok     = cfg_we && s_q.init && !bus_off;
        zero_seg  = (s_q.shadow.tseg1 == '0) && (s_q.shadow.tseg2 == '0);
        if (wr_ok) begin
            if (cfg_sel) begin
                s_d.shadow.tseg1  = cfg_wdata[T1_LSB +: TSEG1_W];
                s_d.shadow.tseg2  = cfg_wdata[T2_LSB +: TSEG2_W];
                s_d.shadow.triple = cfg_wdata[MODE_BIT];
            end else begin
                s_d.shadow.presc  = cfg_wdata[PRESC_W-1:0];
            end
        end
        if (init_wr) begin
            s_d.init = init_val;
        end
        init_fall = s_q.init && !s_d.init;
        if (init_fall && !zero_seg) begin
            s_d.active = s_q.shadow;
            s_d.valid  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= CFG_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign init_o = s_q.init;
    assign act_o  = s_q.active;
    assign run_o  = !s_q.init && s_q.valid;

    // R7: a refused write leaves the shadow registers untouched
    p_wr_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (!s_q.init || bus_off)) |=> $stable(s_q.shadow));

    // R8: active timing moves only on the falling edge of init
    p_load_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !init_fall |=> $stable(s_q.active));

    // R9: an all-zero segment pair never reaches the active timing
    p_zero_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (init_fall && zero_seg) |=> ($stable(s_q.active) && $stable(s_q.valid)));

endmodule

// File: rtl/bt_tq_prescaler.sv
module bt_tq_prescaler
    import can_bt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               restart,
    input  logic [PRESC_W-1:0] presc,
    output logic               tick,
    output logic               q_first
);

    typedef struct packed {
        logic [PRESC_W-1:0] cnt;
    } psc_state_t;

    psc_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!run || restart) begin
            s_d.cnt = '0;
        end else if (s_q.cnt == presc) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + PRESC_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tick    = run && (s_q.cnt == presc);
    assign q_first = (s_q.cnt == '0);

    // R2: the clock count within a quantum never passes the prescaler value
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= presc);

endmodule

// File: rtl/bt_seg_seq.sv
module bt_seg_seq
    import can_bt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               restart,
    input  logic               tick,
    input  logic [TSEG1_W-1:0] tseg1_f,
    input  logic [TSEG2_W-1:0] tseg2_f,
    output logic               bit_start,
    output logic               pre2,
    output logic               pre1,
    output logic               spt
);

    typedef struct packed {
        logic [POS_W-1:0] pos;
    } seq_state_t;

    seq_state_t       s_d, s_q;
    logic [POS_W-1:0] t1_len;
    logic [POS_W-1:0] t2_len;
    logic [POS_W-1:0] last_q;
    logic             adv;

    always_comb begin
        t1_len = seg_len(POS_W'(tseg1_f));
        t2_len = seg_len(POS_W'(tseg2_f));
        last_q = t1_len + t2_len;
        adv    = tick && run && !restart;
        s_d    = s_q;
        if (!run || restart) begin
            s_d.pos = '0;
        end else if (tick) begin
            s_d.pos = (s_q.pos == last_q) ? '0 : s_q.pos + POS_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bit_start = run && (s_q.pos == '0);
    assign spt       = adv && (s_q.pos == t1_len);
    assign pre1      = adv && (s_q.pos == t1_len - POS_W'(1));
    assign pre2      = adv && (s_q.pos == t1_len - POS_W'(2));

    // R2: the quantum index stays inside the programmed bit
    p_pos_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pos <= last_q);

    // R10: an idle sequencer rests at the synchronisation segment
    p_idle_pos_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (s_q.pos == '0));

endmodule

// File: rtl/bt_bus_sampler.sv
module bt_bus_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic rx,
    input  logic run,
    input  logic triple,
    input  logic pre2,
    input  logic pre1,
    input  logic spt,
    output logic hsync,
    output logic smp_stb,
    output logic smp_bit
);

    typedef struct packed {
        logic rx_prev;
        logic s0;
        logic s1;
        logic stb;
        logic bitv;
    } smp_state_t;

    localparam smp_state_t SMP_RST = '{rx_prev: 1'b1, s0: 1'b1, s1: 1'b1, stb: 1'b0, bitv: 1'b1};

    smp_state_t s_d, s_q;
    logic       vote;

    always_comb begin
        s_d         = s_q;
        s_d.rx_prev = rx;
        vote        = (s_q.s0 & s_q.s1) | (s_q.s0 & rx) | (s_q.s1 & rx);
        if (pre2) begin
            s_d.s0 = rx;
        end
        if (pre1) begin
            s_d.s1 = rx;
        end
        s_d.stb = spt;
        if (spt) begin
            s_d.bitv = triple ? vote : rx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= SMP_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign hsync   = run && s_q.rx_prev && !rx && s_q.bitv;
    assign smp_stb = s_q.stb;
    assign smp_bit = s_q.bitv;

    // R4: sample strobes are single-clock pulses
    p_stb_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |=> !smp_stb);

    // R4: the sampled value moves only with a strobe
    p_bit_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !s_d.stb |=> $stable(smp_bit));

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
    import can_bt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             init_wr,
    input  logic             init_val,
    input  logic             bus_off,
    input  logic             rx,
    output logic             init_o,
    output logic             tx_pt,
    output logic             smp_stb,
    output logic             smp_bit
);

    bt_cfg_t act;
    logic    run;
    logic    tick;
    logic    q_first;
    logic    bit_start;
    logic    pre2;
    logic    pre1;
    logic    spt;
    logic    hsync;

    bt_cfg_regs u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .init_wr   (init_wr),
        .init_val  (init_val),
        .bus_off   (bus_off),
        .init_o    (init_o),
        .act_o     (act),
        .run_o     (run)
    );

    bt_tq_prescaler u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (hsync),
        .presc   (act.presc),
        .tick    (tick),
        .q_first (q_first)
    );

    bt_seg_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .restart   (hsync),
        .tick      (tick),
        .tseg1_f   (act.tseg1),
        .tseg2_f   (act.tseg2),
        .bit_start (bit_start),
        .pre2      (pre2),
        .pre1      (pre1),
        .spt       (spt)
    );

    bt_bus_sampler u_smp (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx      (rx),
        .run     (run),
        .triple  (act.triple),
        .pre2    (pre2),
        .pre1    (pre1),
        .spt     (spt),
        .hsync   (hsync),
        .smp_stb (smp_stb),
        .smp_bit (smp_bit)
    );

    assign tx_pt = bit_start && q_first;

    // R11: a hard synchronisation makes the next clock a bit start
    p_hsync_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync && !(init_wr && init_val)) |=> tx_pt);

    // R10: no transmit point while initialisation is set
    p_idle_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        init_o |-> !tx_pt);

    // R12: with a dominant last sample the bus edge is ignored
    p_hsync_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !smp_bit && $past(rx) && !rx && !tx_pt) |=> !tx_pt || $past(tick));

endmodule

// File: tb/can_bit_timer_bench.sv
module can_bit_timer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_sel = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       init_wr = 1'b0;
    logic       init_val = 1'b0;
    logic       bus_off = 1'b0;
    logic       rx = 1'b1;
    logic       init_o;
    logic       tx_pt;
    logic       smp_stb;
    logic       smp_bit;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    can_bit_timer u_can_bit_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .init_wr   (init_wr),
        .init_val  (init_val),
        .bus_off   (bus_off),
        .rx        (rx),
        .init_o    (init_o),
        .tx_pt     (tx_pt),
        .smp_stb   (smp_stb),
        .smp_bit   (smp_bit)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic write_reg(input logic sel, input logic [7:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic program_timing(input logic [7:0] presc, input logic [7:0] segs);
        write_reg(1'b0, presc);
        write_reg(1'b1, segs);
    endtask

    // returns at the falling edge inside the first clock after the init write
    task automatic set_init(input logic v, input logic rxv);
        @(negedge clk);
        init_wr = 1'b1; init_val = v; rx = rxv;
        @(negedge clk);
        init_wr = 1'b0;
    endtask

    // rx stimulus: mode 0 constant, mode 1 hard sync and vote, mode 2 single point
    function automatic logic rx_fn(input int mode, input int k, input int rxv);
        int b;
        int q;
        if (mode == 0) return logic'(rxv);
        if (mode == 2) return (k >= 8);
        if (k < 20) return 1'b1;
        if (k < 35 || k >= 77) return 1'b0;
        b = (k - 35) / 14;
        q = ((k - 35) % 14) / 2;
        if (b == 0) return (q == 3);
        if (b == 1) return (q == 4);
        return (q == 2 || q == 3);
    endfunction

    function automatic int exp_tx(input int mode, input int k, input int bl);
        if (mode == 1 && k >= 21) return int'(((k - 21) % bl) == 0);
        return int'((k % bl) == 0);
    endfunction

    function automatic int exp_smp(input int mode, input int k, input int bl, input int sp);
        if (mode == 1) return int'(k == 10 || (k >= 21 && ((k - 21) % bl) == sp));
        return int'((k % bl) == sp);
    endfunction

    function automatic int exp_bit(input int mode, input int k, input int rxv);
        if (mode == 0) return rxv;
        if (mode == 2) return 1;
        return int'(k == 10 || k == 73);
    endfunction

    task automatic run_mode(input int mode, input int n, input int q, input int t1, input int t2,
                            input int rxv, input string rt, input string rs, input string rb);
        int bl;
        int sp;
        int e;
        bl = (1 + t1 + t2) * q;
        sp = (t1 + 1) * q;
        for (int k = 0; k < n; k++) begin
            rx = rx_fn(mode, k, rxv);
            check(rt, int'(tx_pt), exp_tx(mode, k, bl));
            e = exp_smp(mode, k, bl, sp);
            check(rs, int'(smp_stb), e);
            if (e != 0) check(rb, int'(smp_bit), exp_bit(mode, k, rxv));
            @(negedge clk);
        end
    endtask

    task automatic quiet_window(input int n, input string req);
        int seen;
        seen = 0;
        for (int k = 0; k < n; k++) begin
            if (tx_pt || smp_stb) seen++;
            @(negedge clk);
        end
        check(req, seen, 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 init", int'(init_o), 1);
        check("R1 tx_pt", int'(tx_pt), 0);
        check("R1 smp_stb", int'(smp_stb), 0);
        check("R1 smp_bit", int'(smp_bit), 1);
    endtask

    task automatic t_zero_block();
        set_init(1'b0, 1'b1);
        check("R13 init clear", int'(init_o), 0);
        quiet_window(100, "R9 no activity with unloaded timing");
        set_init(1'b1, 1'b1);
        check("R13 init set", int'(init_o), 1);
    endtask

    task automatic t_basic();
        program_timing(8'd2, 8'h24);
        set_init(1'b0, 1'b1);
        run_mode(0, 81, 3, 5, 3, 1, "R2 R8 tx", "R4 smp", "R5 bit");
    endtask

    task automatic t_write_ignored();
        program_timing(8'd0, 8'h13);
        set_init(1'b1, 1'b1);
        set_init(1'b0, 1'b1);
        run_mode(0, 54, 3, 5, 3, 1, "R7 tx after running write", "R7 smp", "R7 bit");
    endtask

    task automatic t_busoff();
        set_init(1'b1, 1'b1);
        bus_off = 1'b1;
        program_timing(8'd0, 8'h13);
        bus_off = 1'b0;
        set_init(1'b0, 1'b1);
        run_mode(0, 54, 3, 5, 3, 1, "R7 tx after bus-off write", "R7 smp", "R7 bit");
    endtask

    task automatic t_zero_keep();
        set_init(1'b1, 1'b1);
        program_timing(8'd0, 8'h80);
        set_init(1'b0, 1'b1);
        run_mode(0, 54, 3, 5, 3, 1, "R9 tx keeps old timing", "R9 smp", "R9 bit");
    endtask

    task automatic t_clamp_t1();
        set_init(1'b1, 1'b1);
        program_timing(8'd0, 8'h30);
        set_init(1'b0, 1'b1);
        run_mode(0, 21, 1, 2, 4, 1, "R3 R8 tx t1 floor", "R3 smp t1 floor", "R5 bit");
    endtask

    task automatic t_clamp_t2();
        set_init(1'b1, 1'b1);
        program_timing(8'd0, 8'h05);
        set_init(1'b0, 1'b1);
        run_mode(0, 27, 1, 6, 2, 1, "R3 tx t2 floor", "R3 smp t2 floor", "R5 bit");
    endtask

    task automatic t_max();
        set_init(1'b1, 1'b1);
        program_timing(8'd63, 8'h7F);
        set_init(1'b0, 1'b1);
        run_mode(0, 3200, 64, 16, 8, 1, "R2 tx longest bit", "R4 smp longest bit", "R5 bit");
    endtask

    task automatic t_single();
        set_init(1'b1, 1'b1);
        program_timing(8'd1, 8'h13);
        set_init(1'b0, 1'b0);
        run_mode(2, 12, 2, 4, 2, 0, "R2 tx", "R4 smp", "R5 single point value");
    endtask

    task automatic t_majority();
        set_init(1'b1, 1'b1);
        program_timing(8'd1, 8'h93);
        set_init(1'b0, 1'b1);
        run_mode(1, 80, 2, 4, 2, 1, "R11 R12 tx", "R11 smp", "R6 majority value");
    endtask

    task automatic t_idle();
        set_init(1'b1, 1'b0);
        check("R13 init set", int'(init_o), 1);
        quiet_window(60, "R10 idle while init set");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_zero_block();
        t_basic();
        t_write_ignored();
        t_busoff();
        t_zero_keep();
        t_clamp_t1();
        t_clamp_t2();
        t_max();
        t_single();
        t_majority();
        t_idle();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule